// File: doc/BRIEF.md
# Receive Buffer Credit and Pause Tracker

This block counts the receive buffers that software has handed to one DMA receive channel and turns that count into a pause request for the attached MAC. Software arms buffers by writing an allocation register. Each write either adds a value to the running count or, with the top data bit set, replaces the count outright. A forced load of zero is the normal way to clear the count during bring-up. The DMA engine pulses `consume` once for every buffer descriptor it uses up. The count never wraps: it stops at zero on the way down and at its all-ones value on the way up.

Two programmable thresholds give the pause request hysteresis. When the count drops below the low threshold, pause is requested. The request stays up until the count climbs back to the high threshold or above. Software usually places these thresholds at one third and two thirds of the ring. Pause tracking runs only while the channel's flow-control enable is set. The request reaches the MAC only while the global DMA enable is set.

Top module: `fcc_tracker`

## Requirements
- R1: After reset, `credit_cnt` is 0 and `pause_req` is low.
- R2: A write to offset 0xC with bit 31 clear adds the value in bits 30:0 to the count. The new count is visible one cycle after the write.
- R3: A write to offset 0xC with bit 31 set loads the count with bits 30:0, clamped to the maximum count. A `consume` pulse in the same cycle is ignored.
- R4: A `consume` pulse with no allocation write lowers the count by one. At zero, the count stays at zero.
- R5: A `consume` pulse and an adding write in the same cycle change the count by the written value minus one.
- R6: The count saturates at 2^CNT_W-1 and never wraps.
- R7: While flow control is enabled, a count below the low threshold (offset 0x4, bits 30:0) sets the pause state at the next clock edge.
- R8: Once set, the pause state is cleared only when the count is at or above the high threshold (offset 0x8, bits 30:0). A count between the two thresholds holds the state. If a count is both below low and at or above high, setting wins.
- R9: While `rx_flow_enable` is low, the pause state is cleared at every clock edge.
- R10: While `dma_enable` is low, `pause_req` is low. Raising `dma_enable` brings back the held pause state in the same cycle.
- R11: Writes to any offset other than 0x4, 0x8 and 0xC leave the count and the thresholds unchanged.
- R12: Threshold writes take effect one cycle after the write. Pause decisions use the count and thresholds held before that edge, so `pause_req` follows a count change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register offset within the channel window |
| wr_data | input | DATA_W | Write data; the top bit is the force flag for allocation writes |
| dma_enable | input | 1 | Global DMA enable (bit 0 of the controller configuration) |
| rx_flow_enable | input | 1 | Channel flow-control enable (bit 4 of the channel configuration) |
| consume | input | 1 | One buffer descriptor used by the DMA engine |
| credit_cnt | output | CNT_W | Current available-buffer count |
| pause_req | output | 1 | Pause request to the MAC |

## Verification
The hardest state to reach is the upper saturation edge, and especially the cycle where the count is already full and a `consume` pulse coincides with an adding write. Reaching it by single increments would take a thousand writes. The stimulus instead uses a forced load close to the maximum, then an oversized add, then a coincident add and consume. The hysteresis hold band is reached by walking the count one step at a time between the two thresholds, in both directions. The enable gating is then toggled while the pause state is held.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  // Offsets inside one channel's register window
  localparam int unsigned OFS_LOW   = 4;
  localparam int unsigned OFS_HIGH  = 8;
  localparam int unsigned OFS_ALLOC = 12;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LOW,
    SEL_HIGH,
    SEL_ALLOC
  } fcc_sel_e;

endpackage

// File: rtl/fcc_regs.sv
module fcc_regs
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W:0]    thr_low_q,
  output logic [CNT_W:0]    thr_high_q,
  output logic              alloc_add_ev,
  output logic              alloc_force_ev,
  output logic [DATA_W-2:0] field_val
);

  localparam int FIELD_W = DATA_W - 1;
  localparam int LIM     = 1 << CNT_W;

  function automatic fcc_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(OFS_LOW))   return SEL_LOW;
    if (a == ADDR_W'(OFS_HIGH))  return SEL_HIGH;
    if (a == ADDR_W'(OFS_ALLOC)) return SEL_ALLOC;
    return SEL_NONE;
  endfunction

  // Any value above 2^CNT_W compares like 2^CNT_W against the count
  function automatic logic [CNT_W:0] clamp_thr(input logic [FIELD_W-1:0] v);
    if (v > FIELD_W'(LIM)) return (CNT_W+1)'(LIM);
    return v[CNT_W:0];
  endfunction

  fcc_sel_e sel;
  logic     force_flag;

  assign sel            = wr_en ? decode_sel(wr_addr) : SEL_NONE;
  assign force_flag     = wr_data[DATA_W-1];
  assign field_val      = wr_data[FIELD_W-1:0];
  assign alloc_add_ev   = (sel == SEL_ALLOC) && !force_flag;
  assign alloc_force_ev = (sel == SEL_ALLOC) && force_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_low_q  <= '0;
      thr_high_q <= '0;
    end else begin
      if (sel == SEL_LOW)  thr_low_q  <= clamp_thr(field_val);
      if (sel == SEL_HIGH) thr_high_q <= clamp_thr(field_val);
    end
  end

endmodule

// File: rtl/fcc_credit.sv
module fcc_credit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_add_ev,
  input  logic              alloc_force_ev,
  input  logic [DATA_W-2:0] field_val,
  input  logic              consume,
  output logic [CNT_W-1:0]  cnt_q
);

  localparam int FIELD_W = DATA_W - 1;
  localparam int LIM     = 1 << CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Increment clamped to 2^CNT_W: anything larger saturates the same way
  function automatic logic [CNT_W:0] clamp_inc(input logic [FIELD_W-1:0] v);
    if (v > FIELD_W'(LIM)) return (CNT_W+1)'(LIM);
    return v[CNT_W:0];
  endfunction

  function automatic logic [CNT_W-1:0] clamp_load(input logic [FIELD_W-1:0] v);
    if (v > FIELD_W'(CNT_MAX)) return CNT_MAX;
    return v[CNT_W-1:0];
  endfunction

  // count + inc - dec, held inside [0, CNT_MAX]
  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W:0]   inc,
                                                input logic             dec);
    logic [CNT_W:0] tot;
    tot = {1'b0, c} + inc;
    if (dec && tot != '0) tot = tot - 1'b1;
    if (tot > {1'b0, CNT_MAX}) return CNT_MAX;
    return tot[CNT_W-1:0];
  endfunction

  logic [CNT_W:0]   inc_val;
  logic [CNT_W-1:0] cnt_d;

  assign inc_val = alloc_add_ev ? clamp_inc(field_val) : '0;

  always_comb begin
    if (alloc_force_ev) cnt_d = clamp_load(field_val);
    else                cnt_d = sat_step(cnt_q, inc_val, consume);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fcc_pause.sv
module fcc_pause #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W:0]   thr_low,
  input  logic [CNT_W:0]   thr_high,
  input  logic             fc_en,
  output logic             pause_q
);

  logic below_low;
  logic at_high;

  assign below_low = {1'b0, cnt} < thr_low;
  assign at_high   = {1'b0, cnt} >= thr_high;

  always_ff @(posedge clk) begin
    if (!rst_n)         pause_q <= 1'b0;
    else if (!fc_en)    pause_q <= 1'b0;
    else if (below_low) pause_q <= 1'b1;
    else if (at_high)   pause_q <= 1'b0;
  end

endmodule

// File: rtl/fcc_tracker.sv
module fcc_tracker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dma_enable,
  input  logic              rx_flow_enable,
  input  logic              consume,
  output logic [CNT_W-1:0]  credit_cnt,
  output logic              pause_req
);

  // Named internal events, brought out for the checker
  logic              alloc_add_ev;
  logic              alloc_force_ev;
  logic [DATA_W-2:0] inc_field;
  logic [CNT_W:0]    thr_low;
  logic [CNT_W:0]    thr_high;
  logic              pause_state;

  fcc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .thr_low_q      (thr_low),
    .thr_high_q     (thr_high),
    .alloc_add_ev   (alloc_add_ev),
    .alloc_force_ev (alloc_force_ev),
    .field_val      (inc_field)
  );

  fcc_credit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) credit_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_add_ev   (alloc_add_ev),
    .alloc_force_ev (alloc_force_ev),
    .field_val      (inc_field),
    .consume        (consume),
    .cnt_q          (credit_cnt)
  );

  fcc_pause #(.CNT_W(CNT_W)) pause_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (credit_cnt),
    .thr_low  (thr_low),
    .thr_high (thr_high),
    .fc_en    (rx_flow_enable),
    .pause_q  (pause_state)
  );

  assign pause_req = pause_state & dma_enable;

endmodule

// File: rtl/fcc_tracker_chk.sv
module fcc_tracker_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              consume,
  input logic              alloc_add_ev,
  input logic              alloc_force_ev,
  input logic [DATA_W-2:0] inc_field,
  input logic [CNT_W-1:0]  credit_cnt,
  input logic [CNT_W:0]    thr_low,
  input logic [CNT_W:0]    thr_high,
  input logic              rx_flow_enable,
  input logic              dma_enable,
  input logic              pause_state,
  input logic              pause_req
);

  // R4
  consume_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !alloc_add_ev && !alloc_force_ev && credit_cnt != '0)
      |=> credit_cnt == $past(credit_cnt) - 1'b1);

  // R4
  floor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !alloc_add_ev && !alloc_force_ev && credit_cnt == '0)
      |=> credit_cnt == '0);

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_add_ev && !consume) |=> credit_cnt >= $past(credit_cnt));

  // R3
  force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_force_ev && inc_field == '0) |=> credit_cnt == '0);

  // R7
  pause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flow_enable && {1'b0, credit_cnt} < thr_low) |=> pause_state);

  // R8
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flow_enable && pause_state && {1'b0, credit_cnt} < thr_high) |=> pause_state);

  // R9
  fc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_flow_enable |=> !pause_state);

  // R10
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_enable |-> !pause_req);

endmodule

bind fcc_tracker fcc_tracker_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .consume        (consume),
  .alloc_add_ev   (alloc_add_ev),
  .alloc_force_ev (alloc_force_ev),
  .inc_field      (inc_field),
  .credit_cnt     (credit_cnt),
  .thr_low        (thr_low),
  .thr_high       (thr_high),
  .rx_flow_enable (rx_flow_enable),
  .dma_enable     (dma_enable),
  .pause_state    (pause_state),
  .pause_req      (pause_req)
);

// File: tb/fcc_tracker_tb_top.sv
module fcc_tracker_tb_top;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 10;
  localparam longint MAXC = (64'd1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              dma_enable = 1'b0;
  logic              rx_flow_enable = 1'b0;
  logic              consume = 1'b0;
  logic [CNT_W-1:0]  credit_cnt;
  logic              pause_req;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  // Reference state
  longint r_cnt = 0;
  longint r_low = 0;
  longint r_high = 0;
  bit     r_pst = 0;

  always #2 clk = ~clk;

  fcc_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .dma_enable     (dma_enable),
    .rx_flow_enable (rx_flow_enable),
    .consume        (consume),
    .credit_cnt     (credit_cnt),
    .pause_req      (pause_req)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference update from the inputs applied during the cycle
  task automatic model_edge();
    longint fld;
    longint old_cnt;
    old_cnt = r_cnt;
    fld = longint'(wr_data[DATA_W-2:0]);
    if (!rx_flow_enable)       r_pst = 0;
    else if (old_cnt < r_low)  r_pst = 1;
    else if (old_cnt >= r_high) r_pst = 0;
    if (wr_en && wr_addr == 4'h4) r_low = fld;
    if (wr_en && wr_addr == 4'h8) r_high = fld;
    if (wr_en && wr_addr == 4'hC && wr_data[DATA_W-1]) begin
      r_cnt = (fld > MAXC) ? MAXC : fld;
    end else begin
      longint t;
      t = old_cnt - (consume ? 1 : 0);
      if (wr_en && wr_addr == 4'hC) t = t + fld;
      if (t < 0) t = 0;
      if (t > MAXC) t = MAXC;
      r_cnt = t;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    chk(cur_req, longint'(credit_cnt), r_cnt);
    chk(cur_req, longint'(pause_req), longint'(r_pst && dma_enable));
    wr_en = 1'b0;
    consume = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit c);
    wr_en = 1'b1; wr_addr = a; wr_data = d; consume = c;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", longint'(credit_cnt), 0);
    chk("R1", longint'(pause_req), 0);
    rst_n = 1'b1;
    dma_enable = 1'b1;
    rx_flow_enable = 1'b1;

    // R12: thresholds low=4 high=8
    cur_req = "R12";
    wr(4'h4, 32'd4, 0);
    wr(4'h8, 32'd8, 0);
    chk("R12", longint'(pause_req), 1); // count 0 < low seen after low landed
    // R7
    cur_req = "R7";
    idle(1);
    chk("R7", longint'(pause_req), 1);

    // R2: single-buffer adds
    cur_req = "R2";
    for (int i = 0; i < 5; i++) wr(4'hC, 32'd1, 0);
    chk("R2", longint'(credit_cnt), 5);
    // R8: count 5 lies in the hold band
    cur_req = "R8";
    idle(2);
    chk("R8", longint'(pause_req), 1);
    wr(4'hC, 32'd3, 0);
    chk("R8", longint'(pause_req), 1);
    idle(1);
    chk("R8", longint'(pause_req), 0);

    // R4: walk down through the band, pause stays off until below 4
    cur_req = "R4";
    for (int i = 0; i < 4; i++) begin consume = 1'b1; step(); end
    chk("R4", longint'(credit_cnt), 4);
    chk("R8", longint'(pause_req), 0);
    consume = 1'b1; step();
    idle(1);
    chk("R7", longint'(pause_req), 1);

    // R5: add and consume together
    cur_req = "R5";
    wr(4'hC, 32'd3, 1);
    chk("R5", longint'(credit_cnt), 5);

    // R3: forced load with concurrent consume
    cur_req = "R3";
    wr(4'hC, 32'h8000_0000 | 32'd1020, 1);
    chk("R3", longint'(credit_cnt), 1020);
    // R6: saturation at the top
    cur_req = "R6";
    wr(4'hC, 32'd10, 0);
    chk("R6", longint'(credit_cnt), MAXC);
    wr(4'hC, 32'd1, 1);
    chk("R6", longint'(credit_cnt), MAXC);
    wr(4'hC, 32'h7FFF_FFFF, 0);
    chk("R6", longint'(credit_cnt), MAXC);
    wr(4'hC, 32'hFFFF_FFFF, 0);
    chk("R3", longint'(credit_cnt), MAXC);

    // R4: floor at zero
    cur_req = "R4";
    wr(4'hC, 32'h8000_0000, 0);
    chk("R3", longint'(credit_cnt), 0);
    consume = 1'b1; step();
    chk("R4", longint'(credit_cnt), 0);
    wr(4'hC, 32'd0, 1);
    chk("R4", longint'(credit_cnt), 0);

    // R11: other offsets ignored
    cur_req = "R11";
    wr(4'hC, 32'd6, 0);
    wr(4'h0, 32'h55, 0);
    wr(4'h5, 32'h8000_0003, 0);
    wr(4'hD, 32'd9, 0);
    chk("R11", longint'(credit_cnt), 6);
    idle(2);

    // R10: global enable gates the request, state preserved
    cur_req = "R10";
    wr(4'h8, 32'd20, 0);
    wr(4'h4, 32'd10, 0);
    idle(2);
    chk("R7", longint'(pause_req), 1);
    dma_enable = 1'b0;
    #1;
    chk("R10", longint'(pause_req), 0);
    idle(3);
    dma_enable = 1'b1;
    #1;
    chk("R10", longint'(pause_req), 1);

    // R9: flow control off clears the state
    cur_req = "R9";
    rx_flow_enable = 1'b0;
    step();
    chk("R9", longint'(pause_req), 0);
    idle(2);
    rx_flow_enable = 1'b1;
    step();
    step();
    chk("R9", longint'(pause_req), 1);

    // R8: conflicting thresholds, setting wins
    cur_req = "R8";
    wr(4'h8, 32'd0, 0);
    idle(2);
    chk("R8", longint'(pause_req), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule